// File: doc/BRIEF.md
# Padded Stream Word Deserializer

This block sits between a 32-bit streaming source, typically a memory-to-stream DMA channel, and a consumer that wants 136-bit records in one transfer. Software lays every record out in memory as five consecutive 32-bit words. The block gathers those words, keeps the lowest 136 of the 160 gathered bits, and hands the record on through a valid/ready output.

The upstream end-of-packet flag is carried through. A packet that ends part-way through a group closes that group at once. The record is then sent with its missing words zero-filled, and the next group starts again at word 0.

Both sides use the usual streaming handshake: a beat moves only on a cycle where valid and ready are both high. While a finished record is held at the output and the consumer is not taking it, the input ready stays low. No word is accepted that could not be stored. When the consumer is always ready, the input runs at one word per cycle with no bubbles, and the output carries one record per five accepted words.

Top module: `pad_deser`

## Requirements
- R1: After a synchronous active-high reset, `m_valid` is 0 and `s_ready` is 1, and the first word accepted afterwards is taken as word 0 of a new group.
- R2: Five accepted input words form one record. Word k (k = 0..3) lands in bits [32k+31:32k]. Bits [7:0] of word 4 land in bits [135:128], and the upper 24 bits of word 4 are discarded.
- R3: An input word transfers only on a rising edge where `s_valid` and `s_ready` are both 1. Data presented while `s_valid` is 0 does not appear in any record.
- R4: While `m_valid` is 1 and `m_ready` is 0, `s_ready` is 0.
- R5: While `m_valid` is 1 and `m_ready` is 0, on the next cycle `m_valid` stays 1 and `m_data` and `m_last` are unchanged.
- R6: An accepted word with `s_last` = 1 that is word 0 to 3 of its group closes the group. The record holds the words received so far, zeros in every higher bit, and `m_last` = 1.
- R7: A record closed by its fifth word carries `m_last` = 1 exactly when that fifth word had `s_last` = 1, and `m_last` = 0 otherwise.
- R8: The record appears on `m_valid` in the cycle after the closing word is accepted. With `m_ready` held at 1, `s_ready` never drops, so back-to-back words stream without stalls.
- R9: A reset in the middle of a group discards the words already gathered. They never appear in a later record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Block can take an input word |
| s_data | input | 32 | Input word |
| s_last | input | 1 | Input word ends a packet |
| m_valid | output | 1 | Output record valid |
| m_ready | input | 1 | Consumer takes the record |
| m_data | output | 136 | Assembled record |
| m_last | output | 1 | Record ends a packet |

## Verification
The properties keep their own count of accepted words. They assume that `s_last` means something only on an accepted word, and that the inputs settle well before each clock edge, so the count follows the design's group boundaries. The bench changes every input only on the falling clock edge. It raises `s_last` at random positions, including the first and the fifth word of a group. It also drives junk data with `s_valid` low, which the assumption allows and which the properties ignore.

// File: rtl/pad_deser_pkg.sv
package pad_deser_pkg;

    localparam int IN_W_DEFAULT  = 32;
    localparam int REC_W_DEFAULT = 136;

    // Words of input width needed to cover one record (rounded up).
    function automatic int words_per_rec(input int rec_w, input int in_w);
        return (rec_w + in_w - 1) / in_w;
    endfunction

    function automatic int idx_width(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    // What an input cycle does to the current group.
    typedef enum logic [1:0] {
        BEAT_IDLE        = 2'd0,
        BEAT_FILL        = 2'd1,
        BEAT_CLOSE_FULL  = 2'd2,
        BEAT_CLOSE_SHORT = 2'd3
    } beat_kind_e;

    function automatic beat_kind_e classify(input logic fire,
                                            input logic last,
                                            input logic final_slot);
        if (!fire)            return BEAT_IDLE;
        else if (final_slot)  return BEAT_CLOSE_FULL;
        else if (last)        return BEAT_CLOSE_SHORT;
        else                  return BEAT_FILL;
    endfunction

    function automatic logic closes_group(input beat_kind_e k);
        return (k == BEAT_CLOSE_FULL) || (k == BEAT_CLOSE_SHORT);
    endfunction

endpackage

// File: rtl/pad_deser_slot_ctr.sv
module pad_deser_slot_ctr #(
    parameter int WORDS = 5,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             wrap,
    output logic [IDX_W-1:0] slot,
    output logic             at_final
);
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(WORDS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
        end else if (adv) begin
            if (wrap) slot <= '0;
            else      slot <= slot + 1'b1;
        end
    end

    assign at_final = (slot == LAST_SLOT);

endmodule

// File: rtl/pad_deser_assembler.sv
module pad_deser_assembler #(
    parameter int IN_W  = 32,
    parameter int WORDS = 5,
    parameter int REC_W = 136,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             wrap,
    input  logic [IDX_W-1:0] slot,
    input  logic [IN_W-1:0]  word,
    output logic [REC_W-1:0] rec_next
);
    localparam int HELD = WORDS - 1;
    localparam int SPAN = WORDS * IN_W;

    logic [HELD*IN_W-1:0] held_q;
    logic [SPAN-1:0]      span;
    logic                 unused_pad_bits;

    genvar k;
    generate
        for (k = 0; k < WORDS; k++) begin : g_slice
            if (k < HELD) begin : g_stored
                always_ff @(posedge clk) begin
                    if (rst || (adv && wrap)) begin
                        held_q[k*IN_W +: IN_W] <= '0;
                    end else if (adv && (slot == IDX_W'(k))) begin
                        held_q[k*IN_W +: IN_W] <= word;
                    end
                end
                assign span[k*IN_W +: IN_W] =
                    (slot == IDX_W'(k)) ? word : held_q[k*IN_W +: IN_W];
            end else begin : g_tail
                assign span[k*IN_W +: IN_W] =
                    (slot == IDX_W'(k)) ? word : '0;
            end
        end
    endgenerate

    assign rec_next        = span[REC_W-1:0];
    assign unused_pad_bits = ^span[SPAN-1:REC_W];

endmodule

// File: rtl/pad_deser_out_stage.sv
module pad_deser_out_stage #(
    parameter int REC_W = 136
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [REC_W-1:0] rec_in,
    input  logic             last_in,
    input  logic             m_ready,
    output logic             m_valid,
    output logic [REC_W-1:0] m_data,
    output logic             m_last,
    output logic             can_take
);
    always_ff @(posedge clk) begin
        if (rst) begin
            m_valid <= 1'b0;
            m_data  <= '0;
            m_last  <= 1'b0;
        end else if (load) begin
            m_valid <= 1'b1;
            m_data  <= rec_in;
            m_last  <= last_in;
        end else if (m_ready) begin
            m_valid <= 1'b0;
        end
    end

    assign can_take = !m_valid || m_ready;

endmodule

// File: rtl/pad_deser.sv
module pad_deser
    import pad_deser_pkg::*;
#(
    parameter int IN_W  = IN_W_DEFAULT,
    parameter int REC_W = REC_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             s_valid,
    output logic             s_ready,
    input  logic [IN_W-1:0]  s_data,
    input  logic             s_last,
    output logic             m_valid,
    input  logic             m_ready,
    output logic [REC_W-1:0] m_data,
    output logic             m_last
);
    localparam int WORDS = words_per_rec(REC_W, IN_W);
    localparam int IDX_W = idx_width(WORDS);

    logic             fire;
    logic             wrap;
    logic             at_final;
    logic [IDX_W-1:0] slot;
    logic [REC_W-1:0] rec_next;
    beat_kind_e       kind;

    assign fire = s_valid && s_ready;
    assign kind = classify(fire, s_last, at_final);
    assign wrap = closes_group(kind);

    pad_deser_slot_ctr #(
        .WORDS (WORDS),
        .IDX_W (IDX_W)
    ) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .adv      (fire),
        .wrap     (wrap),
        .slot     (slot),
        .at_final (at_final)
    );

    pad_deser_assembler #(
        .IN_W  (IN_W),
        .WORDS (WORDS),
        .REC_W (REC_W),
        .IDX_W (IDX_W)
    ) u_asm (
        .clk      (clk),
        .rst      (rst),
        .adv      (fire),
        .wrap     (wrap),
        .slot     (slot),
        .word     (s_data),
        .rec_next (rec_next)
    );

    pad_deser_out_stage #(
        .REC_W (REC_W)
    ) u_out (
        .clk      (clk),
        .rst      (rst),
        .load     (wrap),
        .rec_in   (rec_next),
        .last_in  (s_last),
        .m_ready  (m_ready),
        .m_valid  (m_valid),
        .m_data   (m_data),
        .m_last   (m_last),
        .can_take (s_ready)
    );

endmodule

// File: rtl/pad_deser_chk.sv
module pad_deser_chk #(
    parameter int WORDS = 5,
    parameter int REC_W = 136
) (
    input logic             clk,
    input logic             rst,
    input logic             s_valid,
    input logic             s_ready,
    input logic             s_last,
    input logic             m_valid,
    input logic             m_ready,
    input logic [REC_W-1:0] m_data,
    input logic             m_last
);
    int unsigned seen;
    logic        in_fire;
    logic        past_rst = 1'b0;

    assign in_fire = s_valid && s_ready;

    always_ff @(posedge clk) begin
        if (rst)                                  seen <= 0;
        else if (in_fire && (s_last || seen == WORDS - 1)) seen <= 0;
        else if (in_fire)                         seen <= seen + 1;
    end

    always_ff @(posedge clk) begin
        past_rst <= rst;
        // R1: the output is idle on the edge right after reset
        if (past_rst) begin
            assert_reset_idle_R1: assert (!m_valid)
                else $error("output valid right after reset");
        end
    end

    assert_full_group_R2: assert property (@(posedge clk) disable iff (rst)
        (in_fire && !s_last && seen == WORDS - 1) |=> m_valid);

    assert_backpressure_R4: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |-> !s_ready);

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

    assert_early_close_R6: assert property (@(posedge clk) disable iff (rst)
        (in_fire && s_last) |=> (m_valid && m_last));

    assert_no_last_R7: assert property (@(posedge clk) disable iff (rst)
        (in_fire && !s_last && seen == WORDS - 1) |=> !m_last);

    assert_ready_when_empty_R8: assert property (@(posedge clk) disable iff (rst)
        !m_valid |-> s_ready);

endmodule

bind pad_deser pad_deser_chk #(
    .WORDS (WORDS),
    .REC_W (REC_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .s_last  (s_last),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_data  (m_data),
    .m_last  (m_last)
);

// File: tb/tb_pad_deser.sv
module tb_pad_deser;
    localparam int IN_W  = 32;
    localparam int REC_W = 136;
    localparam int WORDS = (REC_W + IN_W - 1) / IN_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             s_valid = 1'b0;
    logic             s_ready;
    logic [IN_W-1:0]  s_data = '0;
    logic             s_last = 1'b0;
    logic             m_valid;
    logic             m_ready = 1'b0;
    logic [REC_W-1:0] m_data;
    logic             m_last;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    pad_deser dut (
        .clk(clk), .rst(rst),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last)
    );

    always #4 clk = ~clk;

    // bench model of the group being gathered
    logic [IN_W-1:0]  grp [WORDS];
    int               gcnt = 0;
    logic [REC_W-1:0] exp_data [$];
    logic             exp_last [$];
    string            exp_tag  [$];
    string            phase_tag = "";

    bit               stall_prev = 0;
    logic [REC_W-1:0] prev_data;
    logic             prev_last;
    bit               last_inf, last_outf, last_sready, last_mvalid;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [REC_W-1:0] act, input logic [REC_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [REC_W-1:0] pack_group();
        logic [WORDS*IN_W-1:0] f = '0;
        for (int i = 0; i < gcnt; i++) f[i*IN_W +: IN_W] = grp[i];
        return f[REC_W-1:0];
    endfunction

    task automatic model_accept(input logic [IN_W-1:0] d, input logic l);
        grp[gcnt] = d;
        gcnt++;
        if (l || gcnt == WORDS) begin
            exp_data.push_back(pack_group());
            exp_last.push_back(l);
            if (phase_tag != "")   exp_tag.push_back(phase_tag);
            else if (gcnt < WORDS) exp_tag.push_back("R6");
            else if (l)            exp_tag.push_back("R7");
            else                   exp_tag.push_back("R2");
            gcnt = 0;
        end
    endtask

    task automatic cycle(input logic v, input logic [IN_W-1:0] d,
                         input logic l, input logic r);
        logic [REC_W-1:0] ed;
        logic             el;
        string            et;
        @(negedge clk);
        s_valid = v; s_data = d; s_last = l; m_ready = r;
        #1;
        last_inf    = s_valid && s_ready;
        last_outf   = m_valid && m_ready;
        last_sready = s_ready;
        last_mvalid = m_valid;
        if (stall_prev) begin
            chk(m_valid && m_data == prev_data && m_last == prev_last, "R5",
                "held record changed", m_data, prev_data);
        end
        if (m_valid && !m_ready)
            chk(!s_ready, "R4", "s_ready during stall", REC_W'(s_ready), '0);
        if (last_outf) begin
            if (exp_data.size() == 0) begin
                chk(0, "R3", "unexpected record", m_data, '0);
            end else begin
                ed = exp_data.pop_front();
                el = exp_last.pop_front();
                et = exp_tag.pop_front();
                chk(m_data == ed, et, "record data", m_data, ed);
                chk(m_last == el, et, "record last", REC_W'(m_last), REC_W'(el));
            end
        end
        stall_prev = m_valid && !m_ready;
        prev_data  = m_data;
        prev_last  = m_last;
        if (last_inf) model_accept(d, l);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; s_valid = 0; s_last = 0; m_ready = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        gcnt = 0; stall_prev = 0;
        exp_data.delete(); exp_last.delete(); exp_tag.delete();
        #1;
        chk(!m_valid, "R1", "m_valid after reset", REC_W'(m_valid), '0);
        chk(s_ready, "R1", "s_ready after reset", REC_W'(s_ready), 1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R8 watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        bit               pend;
        logic [IN_W-1:0]  pd;
        logic             pl;
        bit               stalled_seen;
        void'($urandom(32'd20240611));
        do_reset();

        // R2 / R8: five words, consumer ready, full rate
        for (int i = 0; i < WORDS; i++) begin
            cycle(1, 32'hA0A0_0000 + i + (i == 4 ? 32'h5500_0000 : 0), 0, 1);
            chk(last_sready, "R8", "s_ready at full rate", REC_W'(last_sready), 1);
        end
        cycle(0, 32'hDEAD_BEEF, 0, 0);
        chk(last_mvalid, "R8", "record one cycle after fifth word", REC_W'(last_mvalid), 1);
        chk(m_data == {8'h04, 32'hA0A0_0003, 32'hA0A0_0002, 32'hA0A0_0001, 32'hA0A0_0000},
            "R2", "word placement and pad drop", m_data,
            {8'h04, 32'hA0A0_0003, 32'hA0A0_0002, 32'hA0A0_0001, 32'hA0A0_0000});
        cycle(0, 0, 0, 1);

        // R8: two records back to back, no stall
        for (int i = 0; i < 2 * WORDS; i++) begin
            cycle(1, $urandom, 0, 1);
            chk(last_sready, "R8", "s_ready back to back", REC_W'(last_sready), 1);
        end
        cycle(0, 0, 0, 1);

        // R6: early end at word 2, then a one-word packet
        cycle(1, 32'h1111_1111, 0, 1);
        cycle(1, 32'h2222_2222, 0, 1);
        cycle(1, 32'h3333_3333, 1, 1);
        cycle(1, 32'h4444_4444, 1, 1);
        cycle(0, 0, 0, 1);
        // R7: last on the fifth word
        for (int i = 0; i < WORDS; i++) cycle(1, $urandom, i == WORDS - 1, 1);
        cycle(0, 0, 0, 1);

        // R3: gaps with junk data while s_valid is low
        phase_tag = "R3";
        for (int i = 0; i < WORDS; i++) begin
            cycle(0, 32'hBAD0_0000 + i, 1, 1);
            cycle(1, 32'hC0DE_0000 + i, 0, 1);
        end
        cycle(0, 0, 0, 1);
        phase_tag = "";

        // R4 / R5: consumer stalls with input still offered
        for (int i = 0; i < WORDS; i++) cycle(1, $urandom, 0, 1);
        stalled_seen = 0;
        for (int i = 0; i < 6; i++) begin
            cycle(1, 32'h7777_0000 + i, 0, 0);
            if (last_mvalid && !last_sready) stalled_seen = 1;
        end
        chk(stalled_seen, "R4", "stall blocked input", REC_W'(stalled_seen), 1);
        for (int i = 0; i < 12; i++) cycle(1, 32'h8888_0000 + i, 0, 1);
        cycle(0, 0, 0, 1);
        cycle(0, 0, 0, 1);

        // R9: reset in the middle of a group
        for (int i = 0; i < 3; i++) cycle(1, 32'hFEED_0000 + i, 0, 1);
        do_reset();
        phase_tag = "R9";
        for (int i = 0; i < WORDS; i++) cycle(1, 32'h9000_0000 + i, 0, 1);
        cycle(0, 0, 0, 1);
        cycle(0, 0, 0, 1);
        chk(exp_data.size() == 0, "R9", "record after mid-group reset",
            REC_W'(exp_data.size()), '0);
        phase_tag = "";

        // random traffic with legal holding of valid
        pend = 0; pd = '0; pl = 0;
        for (int n = 0; n < 4000; n++) begin
            if (!pend) begin
                pend = ($urandom % 4) != 0;
                pd   = $urandom;
                pl   = ($urandom % 7) == 0;
            end
            cycle(pend, pd, pl, ($urandom % 3) != 0);
            if (last_inf) pend = 0;
        end
        for (int i = 0; i < 4; i++) cycle(0, 0, 0, 1);
        chk(exp_data.size() == 0, "R2", "all records delivered",
            REC_W'(exp_data.size()), '0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule